// File: doc/BRIEF.md
# Programmable Parallel Port Interface

This block puts three 8-bit parallel ports (A, B and C) behind a small host bus. The host drives an 8-bit write data bus with two address bits, an active-low select and active-low read and write strobes. Through the same bus it reads the port values back. A control address accepts two kinds of command, told apart by bit 7. One kind sets the direction of every port and the operating mode of port B. The other sets or clears a single port C line.

Each port drives its pins as a data-out vector and a per-bit output-enable vector, and it receives the pin levels on a separate input vector. Port C is split into two nibbles, and each nibble has its own direction. Port B can also run a strobed handshake. In that mode the three low port C lines carry the strobe or acknowledge input, the buffer flag and the interrupt request. All logic runs on one clock with a synchronous active-low reset. The bus strobes and pin inputs are taken to be synchronous to that clock.

Top module: `pario_unit`

## Requirements
- R1: After reset, every output-enable bit is 0 and every output latch is 0. A control read returns 0x9B, which means all ports are inputs and port B is in simple mode.
- R2: The address selects 0 = port A, 1 = port B, 2 = port C and 3 = control. A control read returns {1, 00, the five mode bits}.
- R3: A control write with bit 7 = 1 loads the mode bits. Bit 4 is the port A direction, bit 3 the upper C nibble, bit 2 the port B handshake enable, bit 1 the port B direction and bit 0 the lower C nibble, where 1 means input. Each port's output-enable is the inverse of its direction bit. Bits 6:5 are ignored.
- R4: Every mode write clears the A, B and C output latches and the port B handshake flags to 0.
- R5: A control write with bit 7 = 0 sets port C line bits[3:1] to the value of bit 0. It changes no other line and does not change the mode. Bits 6:4 are ignored.
- R6: A write to an output port is held on its data-out after the write ends. A read of an output port returns the held value.
- R7: A read of an input port in simple mode returns the live pin levels at the time of the read, without latching them.
- R8: While the select is high, writes have no effect and the read data enable stays low.
- R9: The two port C nibbles follow their own directions. A port C read returns the held value on output bits and the pin level on input bits.
- R10: In handshake input mode (PC2 = strobe, active low), a strobe falling edge captures the port B pins and sets the buffer-full flag on PC1. A strobe rising edge sets the interrupt on PC0 when the enable (the PC2 latch bit) is 1. A port B read returns the captured byte and clears both flags.
- R11: In handshake output mode (PC2 = acknowledge, active low), a port B write drives PC1 low. An acknowledge falling edge drives PC1 high again. An acknowledge rising edge sets the PC0 interrupt when the enable is 1. A port B write clears the interrupt.
- R12: If a handshake set event and a host clear of the same flag happen in the same cycle, the set takes effect.
- R13: In handshake mode, PC0 and PC1 are outputs and PC2 is an input whatever the lower nibble direction. A port C read returns the enable on bit 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cs_n | input | 1 | Select, active low |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| addr | input | 2 | Register select |
| din | input | 8 | Host write data |
| dout | output | 8 | Host read data |
| dout_en | output | 1 | Read data drive enable |
| pa_pin | input | 8 | Port A pin levels |
| pa_out | output | 8 | Port A drive value |
| pa_oe | output | 8 | Port A drive enable |
| pb_pin | input | 8 | Port B pin levels |
| pb_out | output | 8 | Port B drive value |
| pb_oe | output | 8 | Port B drive enable |
| pc_pin | input | 8 | Port C pin levels |
| pc_out | output | 8 | Port C drive value |
| pc_oe | output | 8 | Port C drive enable |

## Verification
Two events can land in the same cycle in the handshake logic: an external strobe edge that sets a flag, and a host read of port B that clears it. The bench aligns them. It releases the strobe on the same clock edge on which the read strobe samples port B, and separately it drops the strobe during a read. It then checks that the interrupt or buffer-full line on port C shows the set value while the other flag shows the read clear. The mode and bit-command decoders are swept over all 32 mode words and all 128 bit-command codes.

// File: rtl/pario_pkg.sv
// Shared constants and types for the parallel port interface.
// Assumes an even port width so port C splits into two equal nibbles.
package pario_pkg;
    localparam int DW     = 8;
    localparam int NIB    = DW / 2;
    localparam int CIDX_W = $clog2(DW);

    localparam logic [1:0] SEL_A   = 2'd0;
    localparam logic [1:0] SEL_B   = 2'd1;
    localparam logic [1:0] SEL_C   = 2'd2;
    localparam logic [1:0] SEL_CTL = 2'd3;

    // Mode word fields, MSB first; a 1 direction bit means input.
    typedef struct packed {
        logic pa_in;
        logic pcu_in;
        logic pb_hs;
        logic pb_in;
        logic pcl_in;
    } cfg_t;

    localparam int   CFG_W   = $bits(cfg_t);
    localparam cfg_t CFG_RST = cfg_t'(5'b11011);

    // Port C lines used by the port B handshake.
    localparam int HS_INTR = 0;
    localparam int HS_FULL = 1;
    localparam int HS_STB  = 2;
endpackage

// File: rtl/pario_ctrl.sv
// Control register decoder: splits control writes into mode loads and
// single-line port C commands, and holds the current mode word.
// Assumes ctl_we is already qualified by select, write strobe and address.
module pario_ctrl
    import pario_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctl_we,
    input  logic [DW-1:0]     wdata,
    output cfg_t              cfg,
    output logic              mode_ld,
    output logic              bit_ld,
    output logic [CIDX_W-1:0] bit_idx,
    output logic              bit_val
);
    // Command format decode on the top data bit.
    always_comb begin
        mode_ld = ctl_we & wdata[DW-1];
        bit_ld  = ctl_we & ~wdata[DW-1];
        bit_idx = wdata[CIDX_W:1];
        bit_val = wdata[0];
    end

    // Mode word register, loaded only by mode commands.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cfg <= CFG_RST;
        else if (mode_ld)
            cfg <= cfg_t'(wdata[CFG_W-1:0]);
    end

    // R5
    bit_cmd_keeps_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bit_ld |=> $stable(cfg));
endmodule

// File: rtl/pario_hs.sv
// Port B strobed handshake engine. In input mode the active-low line is a
// strobe that captures data; in output mode it is an acknowledge. A single
// flag holds buffer-full (input) or data-pending (output).
// Assumes the handshake line is synchronous to clk.
module pario_hs
    import pario_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          en,
    input  logic          dir_in,
    input  logic          line_n,
    input  logic [DW-1:0] pins,
    input  logic          host_rd,
    input  logic          host_wr,
    input  logic          inte,
    output logic          flag,
    output logic          intr,
    output logic [DW-1:0] data_q
);
    logic line_q;
    logic fall;
    logic rise;
    logic host_clr;

    // Previous level of the handshake line for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) line_q <= 1'b1;
        else        line_q <= line_n;
    end

    always_comb begin
        fall     = line_q & ~line_n;
        rise     = ~line_q & line_n;
        host_clr = dir_in ? host_rd : host_wr;
    end

    // Buffer-full / data-pending flag; set events beat host clears.
    always_ff @(posedge clk) begin
        if (!rst_n || clr || !en)
            flag <= 1'b0;
        else if (dir_in) begin
            if (fall)         flag <= 1'b1;
            else if (host_rd) flag <= 1'b0;
        end else begin
            if (host_wr)      flag <= 1'b1;
            else if (fall)    flag <= 1'b0;
        end
    end

    // Interrupt request, gated by the enable; set beats host clear.
    always_ff @(posedge clk) begin
        if (!rst_n || clr || !en)
            intr <= 1'b0;
        else if (rise && inte)
            intr <= 1'b1;
        else if (host_clr)
            intr <= 1'b0;
    end

    // Capture register for strobed input data.
    always_ff @(posedge clk) begin
        if (!rst_n)
            data_q <= '0;
        else if (en && dir_in && fall)
            data_q <= pins;
    end

    // R10
    full_on_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en && dir_in && fall && !clr) |=> flag);
    // R10
    intr_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!inte && !intr) |=> !intr);
    // R11
    pend_on_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !dir_in && host_wr && !clr) |=> flag);
endmodule

// File: rtl/pario_unit.sv
// Three-port parallel interface top. Holds output latches, builds the
// per-bit drive enables and multiplexes host reads.
// Assumes bus strobes are synchronous; a write takes effect on each clock
// edge the strobe is low (all writes are idempotent).
module pario_unit
    import pario_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cs_n,
    input  logic          rd_n,
    input  logic          wr_n,
    input  logic [1:0]    addr,
    input  logic [DW-1:0] din,
    output logic [DW-1:0] dout,
    output logic          dout_en,
    input  logic [DW-1:0] pa_pin,
    output logic [DW-1:0] pa_out,
    output logic [DW-1:0] pa_oe,
    input  logic [DW-1:0] pb_pin,
    output logic [DW-1:0] pb_out,
    output logic [DW-1:0] pb_oe,
    input  logic [DW-1:0] pc_pin,
    output logic [DW-1:0] pc_out,
    output logic [DW-1:0] pc_oe
);
    logic              wr_act, rd_act;
    logic              we_a, we_b, we_c, we_ctl, rd_b;
    cfg_t              cfg;
    logic              mode_ld, bit_ld, bit_val;
    logic [CIDX_W-1:0] bit_idx;
    logic [DW-1:0]     pa_lat, pb_lat, pc_lat;
    logic              hs_flag, hs_intr;
    logic [DW-1:0]     hs_data;
    logic [DW-1:0]     pc_view;

    // Bus qualification and register select.
    always_comb begin
        wr_act  = ~cs_n & ~wr_n;
        rd_act  = ~cs_n & ~rd_n & wr_n;
        we_a    = wr_act && (addr == SEL_A);
        we_b    = wr_act && (addr == SEL_B);
        we_c    = wr_act && (addr == SEL_C);
        we_ctl  = wr_act && (addr == SEL_CTL);
        rd_b    = rd_act && (addr == SEL_B);
        dout_en = rd_act;
    end

    pario_ctrl u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .ctl_we  (we_ctl),
        .wdata   (din),
        .cfg     (cfg),
        .mode_ld (mode_ld),
        .bit_ld  (bit_ld),
        .bit_idx (bit_idx),
        .bit_val (bit_val)
    );

    pario_hs u_hs (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (mode_ld),
        .en      (cfg.pb_hs),
        .dir_in  (cfg.pb_in),
        .line_n  (pc_pin[HS_STB]),
        .pins    (pb_pin),
        .host_rd (rd_b),
        .host_wr (we_b),
        .inte    (pc_lat[HS_STB]),
        .flag    (hs_flag),
        .intr    (hs_intr),
        .data_q  (hs_data)
    );

    // Port A output latch.
    always_ff @(posedge clk) begin
        if (!rst_n || mode_ld) pa_lat <= '0;
        else if (we_a)         pa_lat <= din;
    end

    // Port B output latch.
    always_ff @(posedge clk) begin
        if (!rst_n || mode_ld) pb_lat <= '0;
        else if (we_b)         pb_lat <= din;
    end

    // Port C latch: whole-byte writes and single-line commands.
    always_ff @(posedge clk) begin
        if (!rst_n || mode_ld) pc_lat <= '0;
        else if (we_c)         pc_lat <= din;
        else if (bit_ld)       pc_lat[bit_idx] <= bit_val;
    end

    // Drive values and enables for ports A and B.
    always_comb begin
        pa_out = pa_lat;
        pa_oe  = {DW{~cfg.pa_in}};
        pb_out = pb_lat;
        pb_oe  = {DW{~cfg.pb_in}};
    end

    // Port C per-bit drive, enable and read view; handshake lines override.
    for (genvar i = 0; i < DW; i++) begin : g_pc
        logic dir_in_bit;
        assign dir_in_bit = (i >= NIB) ? cfg.pcu_in : cfg.pcl_in;
        if (i == HS_INTR) begin : g_intr
            assign pc_out[i] = cfg.pb_hs ? hs_intr : pc_lat[i];
            assign pc_oe[i]  = cfg.pb_hs | ~dir_in_bit;
        end else if (i == HS_FULL) begin : g_full
            assign pc_out[i] = cfg.pb_hs ? (cfg.pb_in ? hs_flag : ~hs_flag) : pc_lat[i];
            assign pc_oe[i]  = cfg.pb_hs | ~dir_in_bit;
        end else if (i == HS_STB) begin : g_stb
            assign pc_out[i] = pc_lat[i];
            assign pc_oe[i]  = ~cfg.pb_hs & ~dir_in_bit;
        end else begin : g_plain
            assign pc_out[i] = pc_lat[i];
            assign pc_oe[i]  = ~dir_in_bit;
        end
        if (i == HS_STB) begin : g_view_stb
            assign pc_view[i] = cfg.pb_hs ? pc_lat[i] : (pc_oe[i] ? pc_out[i] : pc_pin[i]);
        end else begin : g_view
            assign pc_view[i] = pc_oe[i] ? pc_out[i] : pc_pin[i];
        end
    end

    // Host read multiplexer.
    always_comb begin
        unique case (addr)
            SEL_A:   dout = cfg.pa_in ? pa_pin : pa_lat;
            SEL_B:   dout = cfg.pb_in ? (cfg.pb_hs ? hs_data : pb_pin) : pb_lat;
            SEL_C:   dout = pc_view;
            default: dout = {1'b1, {(DW-1-CFG_W){1'b0}}, cfg};
        endcase
    end

    // R4
    latch_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mode_ld |=> (pa_lat == '0) && (pb_lat == '0) && (pc_lat == '0));
    // R5
    single_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bit_ld |=> ($countones(pc_lat ^ $past(pc_lat)) <= 1));
    // R8
    deselect_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |=> ($stable(pa_lat) && $stable(pb_lat) && $stable(pc_lat) && $stable(cfg)));
endmodule

// File: tb/pario_unit_tb.sv
`timescale 1ns/1ps
module pario_unit_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cs_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1;
    logic [1:0] addr = 2'd0;
    logic [7:0] din = 8'h00;
    logic [7:0] dout;
    logic       dout_en;
    logic [7:0] pa_pin = 8'hFF, pb_pin = 8'hFF, pc_pin = 8'hFF;
    logic [7:0] pa_out, pa_oe, pb_out, pb_oe, pc_out, pc_oe;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #2 clk = ~clk;

    pario_unit u_dut (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n),
        .addr(addr), .din(din), .dout(dout), .dout_en(dout_en),
        .pa_pin(pa_pin), .pa_out(pa_out), .pa_oe(pa_oe),
        .pb_pin(pb_pin), .pb_out(pb_out), .pb_oe(pb_oe),
        .pc_pin(pc_pin), .pc_out(pc_out), .pc_oe(pc_oe)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic bus_wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        cs_n = 1'b0; wr_n = 1'b0; addr = a; din = d;
        @(negedge clk);
        cs_n = 1'b1; wr_n = 1'b1;
    endtask

    task automatic bus_rd(input logic [1:0] a, output logic [7:0] d, output logic en);
        @(negedge clk);
        cs_n = 1'b0; rd_n = 1'b0; addr = a;
        #1;
        d = dout; en = dout_en;
        @(negedge clk);
        cs_n = 1'b1; rd_n = 1'b1;
    endtask

    function automatic logic [7:0] exp_pcoe(input logic [4:0] m);
        logic [7:0] oe;
        oe = {{4{~m[3]}}, {4{~m[0]}}};
        if (m[2]) begin oe[0] = 1'b1; oe[1] = 1'b1; oe[2] = 1'b0; end
        return oe;
    endfunction

    task automatic finish_run();
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    endtask

    initial begin
        #(4ns * 150000);
        if (!done) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            finish_run();
        end
    end

    initial begin
        logic [7:0] rd;
        logic       en;
        logic [7:0] model;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check("R1 pa_oe", pa_oe, 8'h00);
        check("R1 pb_oe", pb_oe, 8'h00);
        check("R1 pc_oe", pc_oe, 8'h00);
        check("R1 pc_out", pc_out, 8'h00);
        bus_rd(2'd3, rd, en);
        check("R1 R2 control read", rd, 8'h9B);

        // R3 R4 sweep every mode word, bits 6:5 filled to show they are ignored
        for (int m = 0; m < 32; m++) begin
            bus_wr(2'd0, 8'h5A);
            bus_wr(2'd1, 8'hA5);
            bus_wr(2'd2, 8'h3C);
            bus_wr(2'd3, 8'hE0 | m[7:0]);
            check("R3 pa_oe", pa_oe, m[4] ? 8'h00 : 8'hFF);
            check("R3 pb_oe", pb_oe, m[1] ? 8'h00 : 8'hFF);
            check("R3 R13 pc_oe", pc_oe, exp_pcoe(m[4:0]));
            bus_rd(2'd3, rd, en);
            check("R3 control read", rd, 8'h80 | m[7:0]);
            check("R4 pa_out", pa_out, 8'h00);
            check("R4 pb_out", pb_out, 8'h00);
            check("R4 pc_out", pc_out, (m[2] && !m[1]) ? 8'h02 : 8'h00);
        end

        // R6 outputs held and read back
        bus_wr(2'd3, 8'h80);
        for (int v = 0; v < 256; v += 37) begin
            bus_wr(2'd0, v[7:0]);
            bus_wr(2'd1, ~v[7:0]);
            repeat (3) @(negedge clk);
            check("R6 pa_out hold", pa_out, v[7:0]);
            check("R6 pb_out hold", pb_out, ~v[7:0]);
            bus_rd(2'd0, rd, en);
            check("R6 R2 read A latch", rd, v[7:0]);
            bus_rd(2'd1, rd, en);
            check("R6 R2 read B latch", rd, ~v[7:0]);
        end

        // R7 inputs follow live pins
        bus_wr(2'd3, 8'h9B);
        for (int v = 0; v < 256; v += 51) begin
            pa_pin = v[7:0]; pb_pin = v[7:0] ^ 8'h96; pc_pin = v[7:0] + 8'd7;
            bus_rd(2'd0, rd, en);
            check("R7 read A pins", rd, v[7:0]);
            bus_rd(2'd1, rd, en);
            check("R7 read B pins", rd, v[7:0] ^ 8'h96);
            bus_rd(2'd2, rd, en);
            check("R7 R9 read C pins", rd, v[7:0] + 8'd7);
            check("R2 dout_en", {7'd0, en}, 8'h01);
        end
        pa_pin = 8'hFF; pb_pin = 8'hFF; pc_pin = 8'hFF;

        // R8 deselected writes and reads
        bus_wr(2'd3, 8'h80);
        bus_wr(2'd0, 8'h12);
        @(negedge clk); cs_n = 1'b1; wr_n = 1'b0; addr = 2'd0; din = 8'hEE;
        @(negedge clk); addr = 2'd3; din = 8'h9B;
        @(negedge clk); wr_n = 1'b1; rd_n = 1'b0;
        #1 check("R8 dout_en low", {7'd0, dout_en}, 8'h00);
        @(negedge clk); rd_n = 1'b1;
        check("R8 pa_out unchanged", pa_out, 8'h12);
        check("R8 pa_oe unchanged", pa_oe, 8'hFF);

        // R5 exhaustive single-line commands
        bus_wr(2'd2, 8'h00);
        model = 8'h00;
        for (int c = 0; c < 128; c++) begin
            bus_wr(2'd3, c[7:0]);
            model[c[3:1]] = c[0];
            check("R5 pc_out line", pc_out, model);
        end
        bus_rd(2'd3, rd, en);
        check("R5 mode unchanged", rd, 8'h80);
        check("R5 pa_out untouched", pa_out, 8'h12);

        // R9 mixed nibble directions
        bus_wr(2'd3, 8'h81);
        bus_wr(2'd2, 8'hA5);
        pc_pin = 8'h3C;
        check("R9 pc_oe low in", pc_oe, 8'hF0);
        bus_rd(2'd2, rd, en);
        check("R9 read C low in", rd, 8'hAC);
        bus_wr(2'd3, 8'h88);
        bus_wr(2'd2, 8'hA5);
        check("R9 pc_oe up in", pc_oe, 8'h0F);
        bus_rd(2'd2, rd, en);
        check("R9 read C up in", rd, 8'h35);
        pc_pin = 8'hFF;

        // R10 R13 handshake input
        bus_wr(2'd3, 8'h86);
        bus_wr(2'd3, 8'h05);
        check("R13 pc_oe hs", pc_oe, 8'hFB);
        pb_pin = 8'h3E;
        @(negedge clk); pc_pin[2] = 1'b0;
        @(negedge clk);
        check("R10 full after strobe", pc_out & 8'h03, 8'h02);
        pb_pin = 8'h11;
        pc_pin[2] = 1'b1;
        @(negedge clk);
        check("R10 intr after release", pc_out & 8'h03, 8'h03);
        bus_rd(2'd2, rd, en);
        check("R13 status read", rd & 8'h07, 8'h07);
        bus_rd(2'd1, rd, en);
        check("R10 captured byte", rd, 8'h3E);
        check("R10 flags cleared", pc_out & 8'h03, 8'h00);
        bus_wr(2'd3, 8'h04);
        @(negedge clk); pc_pin[2] = 1'b0;
        @(negedge clk); pc_pin[2] = 1'b1;
        @(negedge clk);
        check("R10 no intr when disabled", pc_out & 8'h03, 8'h02);

        // R12 strobe release in same cycle as read of port B
        bus_wr(2'd3, 8'h05);
        bus_rd(2'd1, rd, en);
        @(negedge clk); pc_pin[2] = 1'b0;
        @(negedge clk);
        cs_n = 1'b0; rd_n = 1'b0; addr = 2'd1; pc_pin[2] = 1'b1;
        @(negedge clk); cs_n = 1'b1; rd_n = 1'b1;
        check("R12 intr set beats read", pc_out & 8'h03, 8'h01);
        @(negedge clk);
        cs_n = 1'b0; rd_n = 1'b0; addr = 2'd1; pc_pin[2] = 1'b0;
        @(negedge clk); cs_n = 1'b1; rd_n = 1'b1; pc_pin[2] = 1'b1;
        check("R12 full set beats read", pc_out & 8'h02, 8'h02);

        // R11 handshake output
        bus_wr(2'd3, 8'h84);
        bus_wr(2'd3, 8'h05);
        check("R11 idle line high", pc_out & 8'h03, 8'h02);
        bus_wr(2'd1, 8'h77);
        check("R11 pb_out", pb_out, 8'h77);
        check("R11 pending low", pc_out & 8'h03, 8'h00);
        @(negedge clk); pc_pin[2] = 1'b0;
        @(negedge clk);
        check("R11 ack clears pending", pc_out & 8'h03, 8'h02);
        pc_pin[2] = 1'b1;
        @(negedge clk);
        check("R11 intr on ack release", pc_out & 8'h03, 8'h03);
        bus_wr(2'd1, 8'h78);
        check("R11 write clears intr", pc_out & 8'h03, 8'h00);

        done = 1'b1;
        finish_run();
    end
endmodule